// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block sits beside a processor's load/store port and watches every data access for debug purposes. It holds six independent watchpoints. Each one covers an inclusive address range given by its own start and end registers, and each can be armed to fire on reads, on writes, or on both. A single global enable bit gates all six watchpoints.

Software sets up the unit through a small word-indexed register interface. When an armed range matches an access, the unit raises a one-cycle debug exception request. It also loads a fixed cause code into an exception status register and captures the address of the access in an exception address register. Both registers keep their values until the next hit or until software writes them. When several watchpoints match the same access, the lowest-numbered one is reported.

Top module: `dwatch_top`

## Requirements
- R1: After reset every register reads as zero, every watchpoint is disabled, the global enable is clear, and no exception request is raised.
- R2: The mode word (register index 0) holds one 2-bit field per watchpoint n at bits 2+4n and 3+4n. All other bits are reserved: they read as zero and writes to them are ignored.
- R3: In a mode field, bit 0 arms read triggering and bit 1 arms write triggering. Value 3 fires on either direction, and value 0 never fires.
- R4: An access matches watchpoint n when start <= addr <= end, compared as unsigned 32-bit values, with both edges included.
- R5: The global enable is bit 19 of register index 1, and no watchpoint fires while it is clear. The other bits of that register read as zero. Writing a mode field does not change the enable, and clearing the enable does not change the mode fields.
- R6: A hit sets excReq high for exactly the one cycle after the access is sampled, and loads bits 15:8 of the exception status register (index 2) with 0x0C. The other bits of that register read as zero.
- R7: A hit loads the exception address register (index 3) with the accessed address. That register holds its value through accesses that do not hit.
- R8: When several watchpoints match one access, excWpId reports the lowest-numbered one.
- R9: Software writes to registers 2 and 3 take effect when no hit occurs in the same cycle. A hit in the same cycle takes precedence over the write.
- R10: The start address of watchpoint n is at register index 4+2n and its end address is at index 5+2n. Both read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | 4 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regIdx |
| accValid | input | 1 | Data access present this cycle |
| accWrite | input | 1 | 1 = store, 0 = load |
| accAddr | input | 32 | Data access address |
| excReq | output | 1 | Debug exception request pulse |
| excWpId | output | 3 | Index of the watchpoint that last fired |

## Verification
The hardest situations to reach are the ones where two things happen in the same cycle. One is an access matched by several armed ranges of different directions, where the reported index must follow both the range and the direction test. The other is a hit that lands in the same cycle as a software write to the status or address register. The stimulus layers overlapping ranges, one of them spanning the whole address space, with different modes. It then drives reads and writes at their shared edge, and finally asserts a register write and a hitting access on the same clock. A behavioural model predicts excReq and excWpId on every clock and every readback value.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;
  localparam int DW_W = 32;
  localparam int REG_MODE = 0;
  localparam int REG_GLB = 1;
  localparam int REG_XSTAT = 2;
  localparam int REG_XADDR = 3;
  localparam int REG_RANGE_BASE = 4;
  localparam int GLB_EN_BIT = 19;
  localparam int FIELD_BASE = 2;
  localparam int FIELD_STRIDE = 4;
  localparam logic [7:0] WATCH_CAUSE = 8'h0C;

  // strobes from the register block to the exception datapath
  typedef struct packed {
    logic            wrStat;
    logic            wrAddr;
    logic [DW_W-1:0] data;
  } dw_strb_t;
endpackage

// File: rtl/dwatch_ctrl.sv
module dwatch_ctrl
  import dwatch_pkg::*;
#(
  parameter int NUM_WP = 6,
  parameter int IDX_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         regWrEn,
  input  logic [IDX_W-1:0]             regIdx,
  input  logic [DW_W-1:0]              regWrData,
  output logic [DW_W-1:0]              regRdData,
  input  logic [7:0]                   excStat,
  input  logic [DW_W-1:0]              excAddr,
  output logic [NUM_WP-1:0][1:0]       modeQ,
  output logic [NUM_WP-1:0][DW_W-1:0]  startQ,
  output logic [NUM_WP-1:0][DW_W-1:0]  endQ,
  output logic                         globalEn,
  output dw_strb_t                     strb
);
  localparam int TOP_BIT = FIELD_BASE + FIELD_STRIDE * (NUM_WP - 1) + 1;

  initial begin
    if (TOP_BIT >= DW_W) $error("mode fields do not fit the control word");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ    <= '0;
      startQ   <= '0;
      endQ     <= '0;
      globalEn <= 1'b0;
    end else if (regWrEn) begin
      if (regIdx == IDX_W'(REG_MODE)) begin
        for (int n = 0; n < NUM_WP; n++)
          modeQ[n] <= regWrData[FIELD_BASE + FIELD_STRIDE*n +: 2];
      end
      if (regIdx == IDX_W'(REG_GLB)) globalEn <= regWrData[GLB_EN_BIT];
      for (int n = 0; n < NUM_WP; n++) begin
        if (regIdx == IDX_W'(REG_RANGE_BASE + 2*n))     startQ[n] <= regWrData;
        if (regIdx == IDX_W'(REG_RANGE_BASE + 2*n + 1)) endQ[n]   <= regWrData;
      end
    end
  end

  always_comb begin
    strb.wrStat = regWrEn && (regIdx == IDX_W'(REG_XSTAT));
    strb.wrAddr = regWrEn && (regIdx == IDX_W'(REG_XADDR));
    strb.data   = regWrData;
  end

  always_comb begin
    regRdData = '0;
    if (regIdx == IDX_W'(REG_MODE)) begin
      for (int n = 0; n < NUM_WP; n++)
        regRdData[FIELD_BASE + FIELD_STRIDE*n +: 2] = modeQ[n];
    end
    if (regIdx == IDX_W'(REG_GLB))   regRdData[GLB_EN_BIT] = globalEn;
    if (regIdx == IDX_W'(REG_XSTAT)) regRdData[15:8] = excStat;
    if (regIdx == IDX_W'(REG_XADDR)) regRdData = excAddr;
    for (int n = 0; n < NUM_WP; n++) begin
      if (regIdx == IDX_W'(REG_RANGE_BASE + 2*n))     regRdData = startQ[n];
      if (regIdx == IDX_W'(REG_RANGE_BASE + 2*n + 1)) regRdData = endQ[n];
    end
  end

  AST_GLB_WRITE: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regIdx == IDX_W'(REG_GLB)) |=> (globalEn == $past(regWrData[GLB_EN_BIT]))); // R5
  AST_MODE_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regIdx == IDX_W'(REG_MODE)) |=> $stable(globalEn)); // R5
endmodule

// File: rtl/dwatch_datapath.sv
module dwatch_datapath
  import dwatch_pkg::*;
#(
  parameter int NUM_WP = 6,
  parameter int ID_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         accValid,
  input  logic                         accWrite,
  input  logic [DW_W-1:0]              accAddr,
  input  logic [NUM_WP-1:0][1:0]       modeQ,
  input  logic [NUM_WP-1:0][DW_W-1:0]  startQ,
  input  logic [NUM_WP-1:0][DW_W-1:0]  endQ,
  input  logic                         globalEn,
  input  dw_strb_t                     strb,
  output logic                         excReq,
  output logic [ID_W-1:0]              excWpId,
  output logic [7:0]                   excStat,
  output logic [DW_W-1:0]              excAddr
);
  logic [NUM_WP-1:0] armHit;
  logic              anyHit;
  logic [ID_W-1:0]   hitId;

  for (genvar n = 0; n < NUM_WP; n++) begin : g_cmp
    logic inRange;
    logic dirOk;
    assign inRange   = (accAddr >= startQ[n]) && (accAddr <= endQ[n]);
    assign dirOk     = accWrite ? modeQ[n][1] : modeQ[n][0];
    assign armHit[n] = accValid && globalEn && inRange && dirOk;
  end

  // lowest index wins: scan downward, last assignment sticks
  always_comb begin
    anyHit = 1'b0;
    hitId  = '0;
    for (int n = NUM_WP - 1; n >= 0; n--) begin
      if (armHit[n]) begin
        anyHit = 1'b1;
        hitId  = ID_W'(n);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      excReq  <= 1'b0;
      excWpId <= '0;
      excStat <= '0;
      excAddr <= '0;
    end else begin
      excReq <= anyHit;
      if (anyHit) begin
        excWpId <= hitId;
        excStat <= WATCH_CAUSE;
        excAddr <= accAddr;
      end else begin
        if (strb.wrStat) excStat <= strb.data[15:8];
        if (strb.wrAddr) excAddr <= strb.data;
      end
    end
  end

  AST_CAUSE_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    excReq |-> (excStat == WATCH_CAUSE)); // R6
  AST_REQ_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    excReq |-> ($past(accValid) && $past(globalEn))); // R5
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    excReq |-> (excAddr == $past(accAddr))); // R7
  AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    excReq |-> (excWpId < ID_W'(NUM_WP))); // R8
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!excReq && !$past(strb.wrStat)) |-> $stable(excStat)); // R9
endmodule

// File: rtl/dwatch_top.sv
module dwatch_top
  import dwatch_pkg::*;
#(
  parameter int NUM_WP = 6,
  localparam int IDX_W = $clog2(REG_RANGE_BASE + 2*NUM_WP),
  localparam int ID_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [DW_W-1:0]  regWrData,
  output logic [DW_W-1:0]  regRdData,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [DW_W-1:0]  accAddr,
  output logic             excReq,
  output logic [ID_W-1:0]  excWpId
);
  logic [NUM_WP-1:0][1:0]      modeQ;
  logic [NUM_WP-1:0][DW_W-1:0] startQ;
  logic [NUM_WP-1:0][DW_W-1:0] endQ;
  logic                        globalEn;
  dw_strb_t                    strb;
  logic [7:0]                  excStat;
  logic [DW_W-1:0]             excAddr;

  dwatch_ctrl #(.NUM_WP(NUM_WP), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regIdx(regIdx),
    .regWrData(regWrData), .regRdData(regRdData),
    .excStat(excStat), .excAddr(excAddr),
    .modeQ(modeQ), .startQ(startQ), .endQ(endQ),
    .globalEn(globalEn), .strb(strb)
  );

  dwatch_datapath #(.NUM_WP(NUM_WP), .ID_W(ID_W)) u_dp (
    .clk(clk), .rst(rst), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .modeQ(modeQ), .startQ(startQ), .endQ(endQ),
    .globalEn(globalEn), .strb(strb), .excReq(excReq),
    .excWpId(excWpId), .excStat(excStat), .excAddr(excAddr)
  );
endmodule

// File: tb/dwatch_top_test.sv
module dwatch_top_test;
  localparam int CLK_P = 10;
  localparam int NWP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [3:0]  regIdx = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [31:0] accAddr = '0;
  logic        excReq;
  logic [2:0]  excWpId;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  logic [1:0]  mMode [NWP];
  logic [31:0] mStart [NWP];
  logic [31:0] mEnd [NWP];
  logic        mEn = 0;
  logic [7:0]  mStat = 0;
  logic [31:0] mAddr = 0;
  bit          expReq = 0;
  int          expId = 0;

  dwatch_top uut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regIdx(regIdx),
    .regWrData(regWrData), .regRdData(regRdData), .accValid(accValid),
    .accWrite(accWrite), .accAddr(accAddr), .excReq(excReq), .excWpId(excWpId)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(input int idx);
    logic [31:0] w = '0;
    if (idx == 0) for (int n = 0; n < NWP; n++) w[2 + 4*n +: 2] = mMode[n];
    else if (idx == 1) w[19] = mEn;
    else if (idx == 2) w[15:8] = mStat;
    else if (idx == 3) w = mAddr;
    else if (((idx - 4) % 2) == 0) w = mStart[(idx - 4) / 2];
    else w = mEnd[(idx - 4) / 2];
    return w;
  endfunction

  // one clock: model update from current inputs, then compare at negedge
  task automatic cyc(input string tag);
    int hid = -1;
    if (accValid && mEn) begin
      for (int n = NWP - 1; n >= 0; n--) begin
        if (accAddr >= mStart[n] && accAddr <= mEnd[n] &&
            (accWrite ? mMode[n][1] : mMode[n][0])) hid = n;
      end
    end
    expReq = (hid >= 0);
    if (expReq) begin
      expId = hid;
      mStat = 8'h0C;
      mAddr = accAddr;
    end
    if (regWrEn) begin
      int i = int'(regIdx);
      if (i == 0) for (int n = 0; n < NWP; n++) mMode[n] = regWrData[2 + 4*n +: 2];
      else if (i == 1) mEn = regWrData[19];
      else if (i == 2) begin if (!expReq) mStat = regWrData[15:8]; end
      else if (i == 3) begin if (!expReq) mAddr = regWrData; end
      else if (((i - 4) % 2) == 0) mStart[(i - 4) / 2] = regWrData;
      else mEnd[(i - 4) / 2] = regWrData;
    end
    @(posedge clk);
    @(negedge clk);
    chk(excReq == expReq, {tag, " excReq"}, 32'(excReq), 32'(expReq));
    if (expReq) chk(excWpId == 3'(expId), {tag, " excWpId"}, 32'(excWpId), 32'(expId));
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input string tag);
    regWrEn = 1; regIdx = 4'(idx); regWrData = d;
    cyc(tag);
    regWrEn = 0;
  endtask

  task automatic acc(input bit w, input logic [31:0] a, input string tag);
    accValid = 1; accWrite = w; accAddr = a;
    cyc(tag);
    accValid = 0;
  endtask

  task automatic rd(input int idx, input string tag);
    regIdx = 4'(idx);
    #1;
    chk(regRdData == mRead(idx), tag, regRdData, mRead(idx));
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < NWP; n++) begin mMode[n] = 0; mStart[n] = 0; mEnd[n] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    chk(excReq == 0, "R1 reset excReq", 32'(excReq), 0);
    for (int i = 0; i < 16; i++) rd(i, "R1 reset readback");
    acc(1, 32'h0, "R1 idle access");

    // wp0: write-only over 0x1000..0x100F
    wr(4, 32'h1000, "R10 start0");
    wr(5, 32'h100F, "R10 end0");
    rd(4, "R10 start0 rb"); rd(5, "R10 end0 rb");
    wr(0, 32'hFFFF_FFFF, "R2 all ones");
    rd(0, "R2 reserved bits zero");
    wr(0, 32'h0000_0008, "R2 wp0 write mode");
    rd(0, "R2 wp0 field");
    acc(1, 32'h1000, "R5 no fire while disabled");
    wr(1, 32'hFFFF_FFFF, "R5 enable");
    rd(1, "R5 only enable bit");
    acc(1, 32'h1000, "R4 lower edge write");
    rd(2, "R6 cause code"); rd(3, "R7 captured addr");
    acc(0, 32'h1004, "R3 read ignored by write mode");
    acc(1, 32'h100F, "R4 upper edge");
    rd(3, "R7 upper addr");
    acc(1, 32'h1010, "R4 above end");
    acc(1, 32'h0FFF, "R4 below start");
    rd(3, "R7 holds after misses");

    // wp1 read-only single byte, wp2 both directions
    wr(6, 32'h2000, "R10 start1"); wr(7, 32'h2000, "R10 end1");
    wr(8, 32'h3000, "R10 start2"); wr(9, 32'h30FF, "R10 end2");
    wr(0, 32'h0000_0C48, "R2 modes 0-2");
    rd(0, "R2 modes rb");
    rd(1, "R5 enable kept after mode write");
    acc(0, 32'h2000, "R3 read mode fires");
    acc(1, 32'h2000, "R3 read mode ignores write");
    acc(0, 32'h3080, "R3 both mode read");
    acc(1, 32'h30FF, "R3 both mode write");
    acc(1, 32'h3100, "R4 past end2");

    // priority with overlap and full-range wp5
    wr(12, 32'h1000, "R10 start4"); wr(13, 32'h1000, "R10 end4");
    wr(14, 32'h0, "R10 start5"); wr(15, 32'hFFFF_FFFF, "R10 end5");
    wr(0, 32'h00CC_0C48, "R2 modes all");
    acc(1, 32'h1000, "R8 wp0 beats 4 and 5");
    acc(0, 32'h1000, "R8 read picks wp4");
    acc(0, 32'hFFFF_FFFF, "R4 unsigned top address wp5");
    rd(3, "R7 top address");
    acc(1, 32'h8000_0000, "R8 back-to-back hit wp5");

    // software writes to exception registers
    wr(2, 32'hFFFF_ABFF, "R9 write status");
    rd(2, "R9 status rb");
    wr(3, 32'h1234_5678, "R9 write addr");
    rd(3, "R9 addr rb");
    // write and hit in the same cycle: hit wins
    regWrEn = 1; regIdx = 4'd3; regWrData = 32'hDEAD_BEEF;
    accValid = 1; accWrite = 0; accAddr = 32'h2000;
    cyc("R9 hit beats write");
    regWrEn = 0; accValid = 0;
    rd(3, "R9 addr after collision");

    // disable globally
    wr(1, 32'h0, "R5 disable");
    acc(1, 32'h1000, "R5 disabled no fire");
    rd(0, "R5 modes kept when disabled");
    wr(1, 32'h0008_0000, "R5 re-enable");
    wr(0, 32'h0, "R3 all modes off");
    rd(1, "R5 enable kept after clear");
    acc(1, 32'h1000, "R3 zero mode never fires");
    acc(0, 32'h2000, "R3 zero mode never fires rd");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule